// File: doc/BRIEF.md
# IP and L4 Header Exception Checker

This block checks the network and transport headers of one received packet. Bytes arrive one per beat on a valid/ready stream, starting at the first byte of the IP header, with a last flag on the final byte. The total byte count of the packet is presented alongside the stream and sampled with the first byte. While the bytes go past, the block keeps the header fields it needs and a running ones-complement sum of the IPv4 header. It does not store the payload.

After the last byte is accepted, the block presents one status word for one cycle. The word reports whether the packet is IPv6, whether it carries TCP or UDP, whether it is a fragment, whether an IP exception or a transport error was found, and a prioritised 8-bit error code. The transport checksum is computed outside the block. Its pass/fail result enters on a side input that is sampled with the last byte.

Top module: `ipchk_top`

## Requirements
- R1: A version nibble (byte 0 bits 7:4) other than 4 or 6 sets the IP exception flag with code 1.
- R2: For IPv4 with a complete header, a header whose 16-bit ones-complement word sum over IHL*4 bytes is not 0xFFFF reports IP exception code 2.
- R3: IPv4 with IHL below 5, or a packet length smaller than the header length (IHL*4 for IPv4, 40 for IPv6), reports IP exception code 3.
- R4: A packet length below the declared IP length (IPv4 total length in bytes 2-3; IPv6 40 plus payload length in bytes 4-5) reports code 4. Extra trailing bytes raise no error.
- R5: A zero IPv4 TTL (byte 8) or IPv6 hop limit (byte 7) reports code 5. IPv4 IHL above 5 reports code 6.
- R6: When several IP conditions hold, the lowest code wins. Any IP exception suppresses every transport check, so the IP exception and transport error flags are never both set.
- R7: IPv4 is a fragment when the more-fragments bit (byte 6 bit 5) is set or the 13-bit offset is nonzero. A fragment sets the fragment flag and skips transport checks.
- R8: Transport codes, lowest first: 1 = fewer than 20 (TCP) or 8 (UDP) bytes remain between the header end and the declared IP length; 2 = external checksum-fail input high at the last byte; 3 = UDP length (L4 bytes 4-5) exceeds the remaining bytes; 4 = source or destination port zero.
- R9: TCP flags (L4 byte 13, FIN=bit0, SYN=bit1, RST=bit2, URG=bit5), checked after R8: only FIN gives 8; none gives 9; FIN+RST gives 10; SYN+URG gives 11; SYN+RST gives 12; SYN+FIN gives 13; the lowest applicable code wins.
- R10: The TCP-or-UDP flag is set for protocol / next-header 6 or 17 with version 4 or 6. The IPv6 flag is set for version 6. Transport errors are reported only when the TCP-or-UDP flag is set.
- R11: The status is valid for exactly the one cycle after the last byte is accepted. Ready is low in that cycle, and the next packet is parsed from a cleared state.
- R12: During and right after reset, status valid is low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Block accepts a beat |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Final byte of the packet |
| in_pkt_len | input | LEN_W | Total packet length in bytes, sampled with the first byte |
| in_l4_csum_bad | input | 1 | External transport checksum failure, sampled with the last byte |
| st_valid | output | 1 | Status word valid |
| st_is_v6 | output | 1 | Packet is IPv6 |
| st_tcp_or_udp | output | 1 | Transport is TCP or UDP |
| st_is_frag | output | 1 | IPv4 fragment |
| st_ip_exc | output | 1 | IP exception found |
| st_l4_err | output | 1 | Transport error found |
| st_code | output | 8 | Error code |

## Verification
Some properties are checked by assertions on every cycle. These are the one-cycle status pulse, the ready gap during that pulse, the clearing of the byte position, and the mutual exclusion between IP exceptions and transport errors. Assertions also check that fragments and non-TCP/UDP packets never carry a transport error and that any reported error has a legal nonzero code. The code values are checked by the bench's scenarios against a behavioural model. Those scenarios cover each IP condition and its priority over the others, every TCP flag combination, IPv6 headers, trailing pad, fragments and input gaps.

// File: rtl/ipchk_pkg.sv
package ipchk_pkg;

    localparam int unsigned V4_MIN_IHL   = 5;
    localparam int unsigned V6_HDR_BYTES = 40;
    localparam int unsigned TCP_HDR      = 20;
    localparam int unsigned UDP_HDR      = 8;
    localparam logic [7:0]  PROTO_TCP    = 8'd6;
    localparam logic [7:0]  PROTO_UDP    = 8'd17;

    // Header fields kept while the stream passes
    typedef struct packed {
        logic [7:0]  vihl;     // version / IHL byte
        logic [15:0] v4_len;   // IPv4 total length
        logic [15:0] v6_len;   // IPv6 payload length
        logic [7:0]  b6;       // v4 flags/offset hi, v6 next header
        logic [7:0]  b7;       // v4 offset lo, v6 hop limit
        logic [7:0]  b8;       // v4 TTL
        logic [7:0]  b9;       // v4 protocol
        logic [15:0] sport;
        logic [15:0] dport;
        logic [15:0] ulen;
        logic [5:0]  tflags;
    } hdr_t;

    typedef struct packed {
        logic       is_v6;
        logic       tcp_or_udp;
        logic       is_frag;
        logic       ip_exc;
        logic       l4_err;
        logic [7:0] code;
    } status_t;

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

    function automatic logic [7:0] tcp_flag_code(input logic [5:0] f);
        if (f == 6'h01)            return 8'd8;
        else if (f == 6'h00)       return 8'd9;
        else if (f[0] && f[2])     return 8'd10;
        else if (f[1] && f[5])     return 8'd11;
        else if (f[1] && f[2])     return 8'd12;
        else if (f[1] && f[0])     return 8'd13;
        else                       return 8'd0;
    endfunction

endpackage

// File: rtl/ipchk_capture.sv
module ipchk_capture
    import ipchk_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat,
    input  logic [7:0]       data,
    input  logic             last,
    input  logic [LEN_W-1:0] pkt_len_in,
    input  logic             ext_bad_in,
    output hdr_t             hdr,
    output logic [LEN_W-1:0] pkt_len,
    output logic             csum_ok,
    output logic             ext_bad,
    output logic             done
);

    localparam int unsigned L4_SPAN = TCP_HDR;

    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] l4off;
    logic [LEN_W-1:0] l4rel;
    logic [LEN_W-1:0] v4_hlen;
    logic [15:0]      acc;
    logic [7:0]       hi;
    logic             in_l4;

    assign v4_hlen = LEN_W'({hdr.vihl[3:0], 2'b00});
    assign l4off   = (hdr.vihl[7:4] == 4'd6) ? LEN_W'(V6_HDR_BYTES) : v4_hlen;
    assign l4rel   = idx - l4off;
    assign in_l4   = (idx >= l4off) && (l4rel < LEN_W'(L4_SPAN));
    assign csum_ok = (acc == 16'hFFFF);

    always_ff @(posedge clk) begin
        if (rst || done) begin
            idx     <= '0;
            hdr     <= '0;
            pkt_len <= '0;
            acc     <= '0;
            hi      <= '0;
            ext_bad <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= beat && last;
            if (beat) begin
                idx <= idx + 1'b1;
                if (idx == '0) pkt_len <= pkt_len_in;
                if (last) ext_bad <= ext_bad_in;
                case (idx)
                    LEN_W'(0): hdr.vihl          <= data;
                    LEN_W'(2): hdr.v4_len[15:8]  <= data;
                    LEN_W'(3): hdr.v4_len[7:0]   <= data;
                    LEN_W'(4): hdr.v6_len[15:8]  <= data;
                    LEN_W'(5): hdr.v6_len[7:0]   <= data;
                    LEN_W'(6): hdr.b6            <= data;
                    LEN_W'(7): hdr.b7            <= data;
                    LEN_W'(8): hdr.b8            <= data;
                    LEN_W'(9): hdr.b9            <= data;
                    default: ;
                endcase
                if (in_l4 && idx >= LEN_W'(V4_MIN_IHL * 4)) begin
                    case (l4rel)
                        LEN_W'(0):  hdr.sport[15:8] <= data;
                        LEN_W'(1):  hdr.sport[7:0]  <= data;
                        LEN_W'(2):  hdr.dport[15:8] <= data;
                        LEN_W'(3):  hdr.dport[7:0]  <= data;
                        LEN_W'(4):  hdr.ulen[15:8]  <= data;
                        LEN_W'(5):  hdr.ulen[7:0]   <= data;
                        LEN_W'(13): hdr.tflags      <= data[5:0];
                        default: ;
                    endcase
                end
                // ones-complement word sum over the IPv4 header
                if (!idx[0]) begin
                    hi <= data;
                end else if (idx < v4_hlen) begin
                    acc <= oc_add(acc, {hi, data});
                end
            end
        end
    end

    AST_POS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        done |=> (idx == '0 && acc == '0)); // R11

endmodule

// File: rtl/ipchk_classify.sv
module ipchk_classify
    import ipchk_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  hdr_t             hdr,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             csum_ok,
    input  logic             ext_bad,
    output status_t          st
);

    localparam int unsigned W = LEN_W + 2;

    logic [3:0]   ver, ihl;
    logic         v4, v6, is_tcp, is_udp, tou, frag;
    logic [W-1:0] hlen, decl, plen, need, remain;
    logic [7:0]   hop, proto, ip_code, l4_code;
    logic         short_hdr, csum_bad, trunc, hop0, opts;
    logic         malformed, udp_over, port0;

    always_comb begin
        ver    = hdr.vihl[7:4];
        ihl    = hdr.vihl[3:0];
        v4     = (ver == 4'd4);
        v6     = (ver == 4'd6);
        hlen   = v6 ? W'(V6_HDR_BYTES) : W'({ihl, 2'b00});
        decl   = v6 ? W'(V6_HDR_BYTES) + W'(hdr.v6_len) : W'(hdr.v4_len);
        plen   = W'(pkt_len);
        hop    = v6 ? hdr.b7 : hdr.b8;
        proto  = v6 ? hdr.b6 : hdr.b9;
        is_tcp = (proto == PROTO_TCP);
        is_udp = (proto == PROTO_UDP);
        tou    = (v4 || v6) && (is_tcp || is_udp);
        frag   = v4 && (hdr.b6[5] || ({hdr.b6[4:0], hdr.b7} != 13'd0));

        short_hdr = (v4 && ihl < 4'(V4_MIN_IHL)) || (plen < hlen);
        csum_bad  = v4 && !short_hdr && !csum_ok;
        trunc     = plen < decl;
        hop0      = (hop == 8'd0);
        opts      = v4 && (ihl > 4'(V4_MIN_IHL));

        if (!v4 && !v6)    ip_code = 8'd1;
        else if (csum_bad) ip_code = 8'd2;
        else if (short_hdr) ip_code = 8'd3;
        else if (trunc)    ip_code = 8'd4;
        else if (hop0)     ip_code = 8'd5;
        else if (opts)     ip_code = 8'd6;
        else               ip_code = 8'd0;

        need      = is_tcp ? W'(TCP_HDR) : W'(UDP_HDR);
        malformed = decl < (hlen + need);
        remain    = decl - hlen;
        udp_over  = is_udp && (W'(hdr.ulen) > remain);
        port0     = (hdr.sport == 16'd0) || (hdr.dport == 16'd0);

        if (ip_code != 8'd0 || frag || !tou) l4_code = 8'd0;
        else if (malformed) l4_code = 8'd1;
        else if (ext_bad)   l4_code = 8'd2;
        else if (udp_over)  l4_code = 8'd3;
        else if (port0)     l4_code = 8'd4;
        else if (is_tcp)    l4_code = tcp_flag_code(hdr.tflags);
        else                l4_code = 8'd0;

        st.is_v6      = v6;
        st.tcp_or_udp = tou;
        st.is_frag    = frag;
        st.ip_exc     = (ip_code != 8'd0);
        st.l4_err     = (l4_code != 8'd0);
        st.code       = (ip_code != 8'd0) ? ip_code : l4_code;
    end

endmodule

// File: rtl/ipchk_top.sv
module ipchk_top
    import ipchk_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [LEN_W-1:0] in_pkt_len,
    input  logic             in_l4_csum_bad,
    output logic             st_valid,
    output logic             st_is_v6,
    output logic             st_tcp_or_udp,
    output logic             st_is_frag,
    output logic             st_ip_exc,
    output logic             st_l4_err,
    output logic [7:0]       st_code
);

    hdr_t             hdr;
    status_t          st;
    logic [LEN_W-1:0] pkt_len;
    logic             csum_ok, ext_bad, done, beat;

    assign in_ready = !done;
    assign beat     = in_valid && in_ready;

    ipchk_capture #(.LEN_W(LEN_W)) u_cap (
        .clk(clk), .rst(rst), .beat(beat), .data(in_data), .last(in_last),
        .pkt_len_in(in_pkt_len), .ext_bad_in(in_l4_csum_bad),
        .hdr(hdr), .pkt_len(pkt_len), .csum_ok(csum_ok), .ext_bad(ext_bad),
        .done(done)
    );

    ipchk_classify #(.LEN_W(LEN_W)) u_cls (
        .hdr(hdr), .pkt_len(pkt_len), .csum_ok(csum_ok), .ext_bad(ext_bad),
        .st(st)
    );

    assign st_valid      = done;
    assign st_is_v6      = done && st.is_v6;
    assign st_tcp_or_udp = done && st.tcp_or_udp;
    assign st_is_frag    = done && st.is_frag;
    assign st_ip_exc     = done && st.ip_exc;
    assign st_l4_err     = done && st.l4_err;
    assign st_code       = done ? st.code : 8'd0;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        st_valid |=> !st_valid); // R11
    AST_READY_GAP: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> !in_ready); // R11
    AST_LAST_TO_STATUS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> st_valid); // R11
    AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> !(st_ip_exc && st_l4_err)); // R6
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (st_valid && (st_ip_exc || st_l4_err)) |-> (st_code != 8'd0 && st_code <= 8'd13)); // R6
    AST_FRAG_NO_L4: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_is_frag) |-> !st_l4_err); // R7
    AST_L4_NEEDS_PROTO: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_l4_err) |-> st_tcp_or_udp); // R10
    AST_IP_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ip_exc) |-> (st_code <= 8'd6)); // R5

endmodule

// File: tb/sim_ipchk_top.sv
module sim_ipchk_top;

    typedef logic [7:0] byte_t;
    typedef struct {
        bit    v6, tou, frag, ipx, l4e;
        int    code;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_last = 1'b0, in_l4_csum_bad = 1'b0;
    logic [7:0]  in_data = '0;
    logic [15:0] in_pkt_len = '0;
    logic        in_ready, st_valid, st_is_v6, st_tcp_or_udp, st_is_frag, st_ip_exc, st_l4_err;
    logic [7:0]  st_code;

    int   n_cmp = 0, n_bad = 0, cyc = 0;
    bit   exp_v = 0, done_flag = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    ipchk_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_pkt_len(in_pkt_len),
        .in_l4_csum_bad(in_l4_csum_bad), .st_valid(st_valid), .st_is_v6(st_is_v6),
        .st_tcp_or_udp(st_tcp_or_udp), .st_is_frag(st_is_frag), .st_ip_exc(st_ip_exc),
        .st_l4_err(st_l4_err), .st_code(st_code)
    );

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic chk(string tag, string what, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // expected status pulse: one cycle after an accepted last byte (R11)
    always @(posedge clk) begin
        cyc <= cyc + 1;
        exp_v <= rst ? 1'b0 : (in_valid && in_ready && in_last);
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R11", "st_valid", st_valid, exp_v);
            if (exp_v && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "code", st_code, e.code);
                chk(e.tag, "ip_exc", st_ip_exc, e.ipx);
                chk(e.tag, "l4_err", st_l4_err, e.l4e);
                chk(e.tag, "is_frag", st_is_frag, e.frag);
                chk("R10", "tcp_or_udp", st_tcp_or_udp, e.tou);
                chk("R10", "is_v6", st_is_v6, e.v6);
                chk("R11", "ready_gap", in_ready, 0);
            end
        end
    end

    function automatic int gb(byte_t q[$], int i);
        return (i < q.size()) ? int'(q[i]) : 0;
    endfunction

    function automatic exp_t ref_model(byte_t q[$], bit ext, string tag);
        exp_t e;
        int n = q.size();
        int ver = gb(q, 0) >> 4, ihl = gb(q, 0) & 15;
        bit v4 = (ver == 4), v6 = (ver == 6);
        int hl = v6 ? 40 : ihl * 4;
        int decl = v6 ? 40 + gb(q, 4) * 256 + gb(q, 5) : gb(q, 2) * 256 + gb(q, 3);
        int hop = v6 ? gb(q, 7) : gb(q, 8);
        int proto = v6 ? gb(q, 6) : gb(q, 9);
        bit shrt = (v4 && ihl < 5) || n < hl;
        bit bad = 0;
        int ipc = 0, l4 = 0;
        if (v4 && !shrt) begin
            int s = 0;
            for (int i = 0; i < hl / 2; i++) s += gb(q, 2 * i) * 256 + gb(q, 2 * i + 1);
            while (s > 65535) s = (s & 65535) + (s >> 16);
            bad = (s != 65535);
        end
        if (!v4 && !v6) ipc = 1;
        else if (bad) ipc = 2;
        else if (shrt) ipc = 3;
        else if (n < decl) ipc = 4;
        else if (hop == 0) ipc = 5;
        else if (v4 && ihl > 5) ipc = 6;
        e.v6 = v6;
        e.tou = (v4 || v6) && (proto == 6 || proto == 17);
        e.frag = v4 && (((gb(q, 6) & 32) != 0) || ((gb(q, 6) & 31) * 256 + gb(q, 7)) != 0);
        if (ipc == 0 && !e.frag && e.tou) begin
            int rem = decl - hl;
            int sp = gb(q, hl) * 256 + gb(q, hl + 1);
            int dp = gb(q, hl + 2) * 256 + gb(q, hl + 3);
            int ul = gb(q, hl + 4) * 256 + gb(q, hl + 5);
            int f = gb(q, hl + 13) & 63;
            if (rem < ((proto == 6) ? 20 : 8)) l4 = 1;
            else if (ext) l4 = 2;
            else if (proto == 17 && ul > rem) l4 = 3;
            else if (sp == 0 || dp == 0) l4 = 4;
            else if (proto == 6) begin
                if (f == 1) l4 = 8;
                else if (f == 0) l4 = 9;
                else if ((f & 5) == 5) l4 = 10;
                else if ((f & 34) == 34) l4 = 11;
                else if ((f & 6) == 6) l4 = 12;
                else if ((f & 3) == 3) l4 = 13;
            end
        end
        e.ipx = (ipc != 0);
        e.l4e = (l4 != 0);
        e.code = (ipc != 0) ? ipc : l4;
        e.tag = tag;
        return e;
    endfunction

    function automatic void v4hdr(ref byte_t q[$], input int ihl, input int total, input int ttl,
                                  input int proto, input int fragw, input int ver, input bit corrupt);
        int st = q.size(), s = 0;
        q.push_back(byte_t'((ver << 4) | ihl)); q.push_back(8'h00);
        q.push_back(byte_t'(total >> 8)); q.push_back(byte_t'(total));
        q.push_back(8'h12); q.push_back(8'h34);
        q.push_back(byte_t'(fragw >> 8)); q.push_back(byte_t'(fragw));
        q.push_back(byte_t'(ttl)); q.push_back(byte_t'(proto));
        q.push_back(8'h00); q.push_back(8'h00);
        for (int i = 0; i < 8; i++) q.push_back(byte_t'(10 + i));
        for (int i = 20; i < ihl * 4; i++) q.push_back(8'h01);
        for (int i = 0; i < ihl * 2; i++) s += int'(q[st + 2 * i]) * 256 + int'(q[st + 2 * i + 1]);
        while (s > 65535) s = (s & 65535) + (s >> 16);
        s = (~s) & 65535;
        q[st + 10] = byte_t'(s >> 8);
        q[st + 11] = byte_t'(s) ^ (corrupt ? 8'h01 : 8'h00);
    endfunction

    function automatic void v6hdr(ref byte_t q[$], input int plen, input int nh, input int hop);
        q.push_back(8'h60); q.push_back(8'h00); q.push_back(8'h00); q.push_back(8'h00);
        q.push_back(byte_t'(plen >> 8)); q.push_back(byte_t'(plen));
        q.push_back(byte_t'(nh)); q.push_back(byte_t'(hop));
        for (int i = 0; i < 32; i++) q.push_back(byte_t'(i + 1));
    endfunction

    function automatic void tcphdr(ref byte_t q[$], input int sp, input int dp, input int fl);
        q.push_back(byte_t'(sp >> 8)); q.push_back(byte_t'(sp));
        q.push_back(byte_t'(dp >> 8)); q.push_back(byte_t'(dp));
        for (int i = 0; i < 8; i++) q.push_back(byte_t'(i + 3));
        q.push_back(8'h50); q.push_back(byte_t'(fl));
        for (int i = 0; i < 6; i++) q.push_back(8'h22);
    endfunction

    function automatic void udphdr(ref byte_t q[$], input int sp, input int dp, input int ul);
        q.push_back(byte_t'(sp >> 8)); q.push_back(byte_t'(sp));
        q.push_back(byte_t'(dp >> 8)); q.push_back(byte_t'(dp));
        q.push_back(byte_t'(ul >> 8)); q.push_back(byte_t'(ul));
        q.push_back(8'h00); q.push_back(8'h00);
    endfunction

    task automatic send(byte_t q[$], bit ext, string tag, bit gaps);
        int n = q.size();
        exp_q.push_back(ref_model(q, ext, tag));
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_data = q[i];
            in_last = (i == n - 1);
            in_pkt_len = 16'(n);
            in_l4_csum_bad = ext;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        in_l4_csum_bad = 1'b0;
    endtask

    task automatic tcp4(int total, int ttl, int fl, int sp, int ihl, int fragw, bit corrupt,
                        int pad, bit ext, string tag, bit gaps);
        byte_t q[$];
        v4hdr(q, ihl, total, ttl, 6, fragw, 4, corrupt);
        tcphdr(q, sp, 80, fl);
        for (int i = 0; i < pad; i++) q.push_back(8'hA5);
        send(q, ext, tag, gaps);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "st_valid in reset", st_valid, 0);
        chk("R12", "in_ready in reset", in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "st_valid after reset", st_valid, 0);
        chk("R12", "in_ready after reset", in_ready, 1);

        // clean TCP (SYN+ACK) -> no error
        tcp4(40, 64, 8'h12, 1234, 5, 0, 0, 0, 0, "R10", 0);
        // R1: bad version
        begin byte_t q[$]; v4hdr(q, 5, 40, 64, 6, 0, 5, 0); tcphdr(q, 1, 2, 8'h12); send(q, 0, "R1", 1); end
        // R2: header checksum wrong, and wrong checksum with TTL 0 (priority)
        tcp4(40, 64, 8'h12, 1234, 5, 0, 1, 0, 0, "R2", 0);
        tcp4(40, 0, 8'h12, 1234, 5, 0, 1, 0, 0, "R2", 1);
        // R3: only 12 bytes of header
        begin byte_t q[$]; v4hdr(q, 5, 40, 64, 6, 0, 4, 0); while (q.size() > 12) void'(q.pop_back()); send(q, 0, "R3", 0); end
        // R3: IHL below 5
        begin byte_t q[$]; v4hdr(q, 5, 40, 64, 6, 0, 4, 0); tcphdr(q, 1, 2, 8'h12); q[0] = 8'h44; send(q, 0, "R3", 0); end
        // R4: declared longer than packet, then trailing pad accepted
        tcp4(60, 64, 8'h12, 1234, 5, 0, 0, 0, 0, "R4", 0);
        tcp4(40, 64, 8'h12, 1234, 5, 0, 0, 6, 0, "R4", 1);
        // R5: TTL 0, options, options + TTL 0
        tcp4(40, 0, 8'h12, 1234, 5, 0, 0, 0, 0, "R5", 0);
        tcp4(44, 64, 8'h12, 1234, 6, 0, 0, 0, 0, "R5", 0);
        tcp4(44, 0, 8'h12, 1234, 6, 0, 0, 0, 0, "R6", 1);
        // R6: IP exception hides zero port
        tcp4(40, 0, 8'h12, 0, 5, 0, 0, 0, 0, "R6", 0);
        // R7: fragments with illegal flags
        tcp4(40, 64, 8'h00, 1234, 5, 16'h2000, 0, 0, 0, "R7", 0);
        tcp4(40, 64, 8'h00, 1234, 5, 16'h0005, 0, 0, 0, "R7", 1);
        // R8: malformed, external checksum, UDP length, zero port
        tcp4(30, 64, 8'h12, 1234, 5, 0, 0, 0, 0, "R8", 0);
        tcp4(40, 64, 8'h12, 1234, 5, 0, 0, 0, 1, "R8", 0);
        begin byte_t q[$]; v4hdr(q, 5, 32, 64, 17, 0, 4, 0); udphdr(q, 53, 53, 20);
              repeat (4) q.push_back(8'h33); send(q, 0, "R8", 1); end
        begin byte_t q[$]; v4hdr(q, 5, 32, 64, 17, 0, 4, 0); udphdr(q, 0, 53, 12);
              repeat (4) q.push_back(8'h33); send(q, 0, "R8", 0); end
        // R9: TCP flag combinations
        tcp4(40, 64, 8'h01, 1234, 5, 0, 0, 0, 0, "R9", 0);
        tcp4(40, 64, 8'h00, 1234, 5, 0, 0, 0, 0, "R9", 1);
        tcp4(40, 64, 8'h05, 1234, 5, 0, 0, 0, 0, "R9", 0);
        tcp4(40, 64, 8'h22, 1234, 5, 0, 0, 0, 0, "R9", 0);
        tcp4(40, 64, 8'h06, 1234, 5, 0, 0, 0, 0, "R9", 1);
        tcp4(40, 64, 8'h03, 1234, 5, 0, 0, 0, 0, "R9", 0);
        tcp4(40, 64, 8'h07, 1234, 5, 0, 0, 0, 0, "R9", 0);
        tcp4(40, 64, 8'h18, 1234, 5, 0, 0, 0, 0, "R9", 1);
        // R10: IPv6 UDP, IPv6 TCP FIN only, non-TCP/UDP protocol
        begin byte_t q[$]; v6hdr(q, 12, 17, 32); udphdr(q, 7, 9, 12); repeat (4) q.push_back(8'h44); send(q, 0, "R10", 1); end
        begin byte_t q[$]; v6hdr(q, 20, 6, 32); tcphdr(q, 7, 9, 8'h01); send(q, 0, "R10", 0); end
        begin byte_t q[$]; v4hdr(q, 5, 28, 64, 1, 0, 4, 0); repeat (8) q.push_back(8'h08); send(q, 0, "R10", 0); end
        // R5: IPv6 hop limit zero
        begin byte_t q[$]; v6hdr(q, 12, 17, 0); udphdr(q, 7, 9, 12); repeat (4) q.push_back(8'h44); send(q, 0, "R5", 0); end
        // R11: back-to-back clean packet after an error
        tcp4(40, 64, 8'h12, 1234, 5, 0, 0, 0, 0, "R11", 0);

        repeat (5) @(negedge clk);
        chk("R11", "pending status", exp_q.size(), 0);
        finish_run();
    end

endmodule